// File: doc/BRIEF.md
# Wake-on-Data Core Clock Gate Controller

This controller sits next to a small processor core and owns that core's clock. When the core finds no input waiting, it can ask to sleep. It first runs a bounded wait: a start strobe arms an idle timer, and the core polls its input channel until data shows up or the timer runs out. If the timer runs out, the core issues a one-cycle sleep request. The controller then raises a sleep indication to the power manager. One cycle later it stops the core's clock on a clean low phase.

Valid data on the core's input channel wakes the core, with no interrupt involved. The controller drops the sleep indication, sends the power manager a one-cycle wake pulse and lets the clock through again, so the core picks up where it stopped. A request that meets arriving data is cancelled, so the core never sleeps with input pending.

A small register file sits on a 6-bit address bus. It holds the core mode, clock-rate selection, supply-voltage selection and the idle timeout. Next to it is a save store that keeps the core's registers across a power-down. A counter of gated cycles supports power profiling.

Top module: `wake_clk_gate`

## Requirements
- R1: After reset, gated_o=0, pm_sleep_o=0, pm_wake_o=0 and gated_cnt_o=0. The settings read back as mode 0, rate 0, voltage 4 (nominal) and the timeout default of 8.
- R2: A sleep request sampled while running, with chan_valid_i low, sets pm_sleep_o at that edge. gated_o rises at the next edge. The gate enable never falls unless pm_sleep_o was already high.
- R3: While gated_o is high, core_clk_o has no rising edge. While running, core_clk_o pulses once per clk_i cycle.
- R4: chan_valid_i sampled while gated clears gated_o and pm_sleep_o at that edge and pulses pm_wake_o for exactly one cycle. core_clk_o pulses again from the following edge.
- R5: A sleep request sampled together with chan_valid_i is dropped: pm_sleep_o stays 0 and the block never gates.
- R6: chan_valid_i sampled in the cycle after the request (pm_sleep_o=1, gated_o=0) aborts gating. pm_sleep_o returns to 0 and gated_o stays 0.
- R7: wait_start_i loads the timeout T (address 0x03), sets timer_busy_o and clears timer_expired_o. timer_expired_o rises T+1 edges after the start edge, and timer_busy_o falls at the same edge.
- R8: chan_valid_i or sleep_req_i sampled while the timer is busy stops it without expiry: timer_busy_o=0 and timer_expired_o=0 after that edge.
- R9: gated_cnt_o goes up by one for every edge sampled with the block gated and holds otherwise. A gated span of N edges, ending with the wake edge, adds N.
- R10: Writes with reg_we_i store the mode at 0x00 (2 bits), the rate at 0x01 (3 bits), the voltage at 0x02 (3 bits) and the timeout at 0x03 (16 bits). Read data for the address applied before an edge appears after it.
- R11: Addresses outside 0x00-0x03 and the save window ignore writes and read as 0.
- R12: The save store at 0x20-0x2F holds full 16-bit words, and its contents survive a gated period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | free-running clock |
| rst_i | input | 1 | synchronous active-high reset |
| sleep_req_i | input | 1 | one-cycle clock-off request from the core |
| chan_valid_i | input | 1 | valid data present on the core's input channel |
| wait_start_i | input | 1 | arms the idle timer at the start of a wait |
| reg_addr_i | input | 6 | register / save-store address |
| reg_wdata_i | input | DW | write data |
| reg_we_i | input | 1 | write strobe |
| reg_rdata_o | output | DW | registered read data |
| core_clk_o | output | 1 | gated clock to the core |
| pm_sleep_o | output | 1 | sleep indication to the power manager |
| pm_wake_o | output | 1 | one-cycle wake pulse to the power manager |
| gated_o | output | 1 | status: 0 running, 1 gated |
| gated_cnt_o | output | CW | count of gated cycles |
| timer_busy_o | output | 1 | idle timer counting |
| timer_expired_o | output | 1 | idle timer ran out during the last wait |
| mode_o | output | 2 | core mode setting |
| rate_o | output | 3 | clock-rate selection |
| volt_o | output | 3 | supply-voltage selection |

## Verification
The checker watches every cycle for several rules. It confirms that the power manager is told before the enable drops and that a request meeting data is dropped. It also checks that a wake clears the gated status with a single wake pulse, that the gated counter steps only while gated, and that channel data halts a busy timer. Other behaviour shows only in the bench's scenarios, because it depends on what happened cycles earlier or on the clock waveform itself. This covers the absence of core clock edges during a gated stretch, timer expiry after exactly T+1 cycles, the field widths and unmapped addresses of the register map, and the save store keeping its contents through a sleep.

// File: rtl/wake_gate_pkg.sv
package wake_gate_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_NOTIFY = 2'd1,
    ST_GATED  = 2'd2
  } gate_state_e;

  localparam logic [5:0] ADDR_MODE    = 6'h00;
  localparam logic [5:0] ADDR_RATE    = 6'h01;
  localparam logic [5:0] ADDR_VOLT    = 6'h02;
  localparam logic [5:0] ADDR_TIMEOUT = 6'h03;
  localparam logic [5:0] ADDR_SAVE    = 6'h20;

  localparam int MODE_W = 2;
  localparam int RATE_W = 3;
  localparam int VOLT_W = 3;
endpackage

// File: rtl/gate_csr_bank.sv
module gate_csr_bank
  import wake_gate_pkg::*;
#(
  parameter int DW          = 16,
  parameter int TW          = 16,
  parameter int SAVE_DEPTH  = 16,
  parameter int VOLT_NOM    = 4,
  parameter int TIMEOUT_RST = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [5:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              we_i,
  output logic [DW-1:0]     rdata_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [RATE_W-1:0] rate_o,
  output logic [VOLT_W-1:0] volt_o,
  output logic [TW-1:0]     timeout_o
);
  localparam int SAVE_AW = (SAVE_DEPTH > 1) ? $clog2(SAVE_DEPTH) : 1;

  logic [DW-1:0] save_mem [SAVE_DEPTH];
  logic [DW-1:0] save_rd_q;
  logic [DW-1:0] csr_rd_q;
  logic          sel_save_q;
  logic [5:0]    save_off;
  logic          save_hit;
  logic [SAVE_AW-1:0] save_idx;

  always_comb begin
    save_off = addr_i - ADDR_SAVE;
    save_hit = (addr_i >= ADDR_SAVE) && (int'(save_off) < SAVE_DEPTH);
    save_idx = SAVE_AW'(save_off);
  end

  // save store: plain synchronous RAM, no reset, so block RAM fits
  always_ff @(posedge clk_i) begin
    if (we_i && save_hit) save_mem[save_idx] <= wdata_i;
    save_rd_q <= save_mem[save_idx];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_o    <= '0;
      rate_o    <= '0;
      volt_o    <= VOLT_W'(VOLT_NOM);
      timeout_o <= TW'(TIMEOUT_RST);
    end else if (we_i) begin
      case (addr_i)
        ADDR_MODE:    mode_o    <= wdata_i[MODE_W-1:0];
        ADDR_RATE:    rate_o    <= wdata_i[RATE_W-1:0];
        ADDR_VOLT:    volt_o    <= wdata_i[VOLT_W-1:0];
        ADDR_TIMEOUT: timeout_o <= wdata_i[TW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      csr_rd_q   <= '0;
      sel_save_q <= 1'b0;
    end else begin
      sel_save_q <= save_hit;
      case (addr_i)
        ADDR_MODE:    csr_rd_q <= DW'(mode_o);
        ADDR_RATE:    csr_rd_q <= DW'(rate_o);
        ADDR_VOLT:    csr_rd_q <= DW'(volt_o);
        ADDR_TIMEOUT: csr_rd_q <= DW'(timeout_o);
        default:      csr_rd_q <= '0;
      endcase
    end
  end

  assign rdata_o = sel_save_q ? save_rd_q : csr_rd_q;
endmodule

// File: rtl/gate_idle_timer.sv
module gate_idle_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [TW-1:0] timeout_i,
  output logic          busy_o,
  output logic          expired_o
);
  logic [TW-1:0] count_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      count_q   <= '0;
      busy_o    <= 1'b0;
      expired_o <= 1'b0;
    end else if (start_i) begin
      count_q   <= timeout_i;
      busy_o    <= 1'b1;
      expired_o <= 1'b0;
    end else if (busy_o) begin
      if (stop_i) begin
        busy_o <= 1'b0;
      end else if (count_q == '0) begin
        busy_o    <= 1'b0;
        expired_o <= 1'b1;
      end else begin
        count_q <= count_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/gate_seq_fsm.sv
module gate_seq_fsm
  import wake_gate_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          sleep_req_i,
  input  logic          chan_valid_i,
  output logic          clk_en_o,
  output logic          pm_sleep_o,
  output logic          pm_wake_o,
  output logic          gated_o,
  output logic [CW-1:0] gated_cnt_o
);
  gate_state_e state_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q     <= ST_RUN;
      clk_en_o    <= 1'b1;
      pm_sleep_o  <= 1'b0;
      pm_wake_o   <= 1'b0;
      gated_o     <= 1'b0;
      gated_cnt_o <= '0;
    end else begin
      pm_wake_o <= 1'b0;
      case (state_q)
        ST_RUN: begin
          if (sleep_req_i && !chan_valid_i) begin
            state_q    <= ST_NOTIFY;
            pm_sleep_o <= 1'b1;
          end
        end
        ST_NOTIFY: begin
          if (chan_valid_i) begin
            state_q    <= ST_RUN;
            pm_sleep_o <= 1'b0;
          end else begin
            state_q  <= ST_GATED;
            clk_en_o <= 1'b0;
            gated_o  <= 1'b1;
          end
        end
        ST_GATED: begin
          gated_cnt_o <= gated_cnt_o + 1'b1;
          if (chan_valid_i) begin
            state_q    <= ST_RUN;
            clk_en_o   <= 1'b1;
            gated_o    <= 1'b0;
            pm_sleep_o <= 1'b0;
            pm_wake_o  <= 1'b1;
          end
        end
        default: begin
          state_q    <= ST_RUN;
          clk_en_o   <= 1'b1;
          gated_o    <= 1'b0;
          pm_sleep_o <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/gate_clk_cell.sv
module gate_clk_cell (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_lat;

  // enable only moves while the clock is low: no runt pulses
  always_latch begin
    if (!clk_i) en_lat = en_i;
  end

  assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/wake_clk_gate.sv
module wake_clk_gate
  import wake_gate_pkg::*;
#(
  parameter int DW          = 16,
  parameter int TW          = 16,
  parameter int CW          = 16,
  parameter int SAVE_DEPTH  = 16,
  parameter int VOLT_NOM    = 4,
  parameter int TIMEOUT_RST = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          sleep_req_i,
  input  logic          chan_valid_i,
  input  logic          wait_start_i,
  input  logic [5:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  input  logic          reg_we_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          core_clk_o,
  output logic          pm_sleep_o,
  output logic          pm_wake_o,
  output logic          gated_o,
  output logic [CW-1:0] gated_cnt_o,
  output logic          timer_busy_o,
  output logic          timer_expired_o,
  output logic [1:0]    mode_o,
  output logic [2:0]    rate_o,
  output logic [2:0]    volt_o
);
  logic          gate_en;
  logic [TW-1:0] timeout;
  logic          timer_stop;

  assign timer_stop = chan_valid_i | sleep_req_i;

  gate_csr_bank #(
    .DW(DW), .TW(TW), .SAVE_DEPTH(SAVE_DEPTH),
    .VOLT_NOM(VOLT_NOM), .TIMEOUT_RST(TIMEOUT_RST)
  ) i_csr (
    .clk_i(clk_i), .rst_i(rst_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .we_i(reg_we_i), .rdata_o(reg_rdata_o),
    .mode_o(mode_o), .rate_o(rate_o), .volt_o(volt_o), .timeout_o(timeout)
  );

  gate_idle_timer #(.TW(TW)) i_timer (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(wait_start_i),
    .stop_i(timer_stop), .timeout_i(timeout),
    .busy_o(timer_busy_o), .expired_o(timer_expired_o)
  );

  gate_seq_fsm #(.CW(CW)) i_fsm (
    .clk_i(clk_i), .rst_i(rst_i), .sleep_req_i(sleep_req_i),
    .chan_valid_i(chan_valid_i), .clk_en_o(gate_en),
    .pm_sleep_o(pm_sleep_o), .pm_wake_o(pm_wake_o),
    .gated_o(gated_o), .gated_cnt_o(gated_cnt_o)
  );

  gate_clk_cell i_cell (
    .clk_i(clk_i), .en_i(gate_en), .gclk_o(core_clk_o)
  );
endmodule

// File: rtl/wake_clk_gate_chk.sv
module wake_clk_gate_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          sleep_req_i,
  input logic          chan_valid_i,
  input logic          wait_start_i,
  input logic          gate_en,
  input logic          pm_sleep_o,
  input logic          pm_wake_o,
  input logic          gated_o,
  input logic [CW-1:0] gated_cnt_o,
  input logic          timer_busy_o,
  input logic          timer_expired_o
);
  AST_NOTIFY_BEFORE_STOP: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(gate_en) |-> $past(pm_sleep_o)); // R2
  AST_CANCEL_SAME_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (sleep_req_i && chan_valid_i && !pm_sleep_o && !gated_o) |=> !pm_sleep_o); // R5
  AST_WAKE_ON_DATA: assert property (@(posedge clk_i) disable iff (rst_i)
    (gated_o && chan_valid_i) |=> (!gated_o && pm_wake_o && !pm_sleep_o)); // R4
  AST_WAKE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    pm_wake_o |=> !pm_wake_o); // R4
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    gated_o |=> (gated_cnt_o == CW'($past(gated_cnt_o) + 1'b1))); // R9
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !gated_o |=> $stable(gated_cnt_o)); // R9
  AST_TIMER_STOP: assert property (@(posedge clk_i) disable iff (rst_i)
    (timer_busy_o && chan_valid_i && !wait_start_i) |=> (!timer_busy_o && !timer_expired_o)); // R8
endmodule

bind wake_clk_gate wake_clk_gate_chk #(.CW(CW)) i_chk (
  .clk_i(clk_i), .rst_i(rst_i), .sleep_req_i(sleep_req_i),
  .chan_valid_i(chan_valid_i), .wait_start_i(wait_start_i),
  .gate_en(gate_en), .pm_sleep_o(pm_sleep_o), .pm_wake_o(pm_wake_o),
  .gated_o(gated_o), .gated_cnt_o(gated_cnt_o),
  .timer_busy_o(timer_busy_o), .timer_expired_o(timer_expired_o)
);

// File: tb/test_wake_clk_gate.sv
`timescale 1ns/1ps
module test_wake_clk_gate;
  logic        clk_i = 1'b0;
  logic        rst_i;
  logic        sleep_req_i, chan_valid_i, wait_start_i, reg_we_i;
  logic [5:0]  reg_addr_i;
  logic [15:0] reg_wdata_i, reg_rdata_o, gated_cnt_o;
  logic        core_clk_o, pm_sleep_o, pm_wake_o, gated_o;
  logic        timer_busy_o, timer_expired_o;
  logic [1:0]  mode_o;
  logic [2:0]  rate_o, volt_o;

  int errors = 0;
  int checks = 0;
  int core_edges = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;
  always @(posedge core_clk_o) core_edges++;

  wake_clk_gate i_wake_clk_gate (.*);

  // {addr, write data, expected readback}
  localparam logic [37:0] VEC [8] = '{
    {6'h00, 16'h0003, 16'h0003},  // R10 mode
    {6'h01, 16'h00FD, 16'h0005},  // R10 rate, 3 bits kept
    {6'h02, 16'h0001, 16'h0001},  // R10 voltage
    {6'h03, 16'h0006, 16'h0006},  // R10 timeout = 6
    {6'h20, 16'hBEEF, 16'hBEEF},  // R12 first save word
    {6'h2F, 16'h1234, 16'h1234},  // R12 last save word
    {6'h30, 16'h5555, 16'h0000},  // R11 past save window
    {6'h07, 16'hAAAA, 16'h0000}   // R11 hole in map
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic read_reg(input logic [5:0] a);
    reg_addr_i = a; reg_we_i = 1'b0; tick();
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_i = 1; sleep_req_i = 0; chan_valid_i = 0; wait_start_i = 0;
    reg_we_i = 0; reg_addr_i = 0; reg_wdata_i = 0;
    tick(3);
    rst_i = 0;
    tick();
    // R1 reset state
    check("R1 gated", gated_o, 0);
    check("R1 pm_sleep", pm_sleep_o, 0);
    check("R1 pm_wake", pm_wake_o, 0);
    check("R1 count", gated_cnt_o, 0);
    check("R1 mode", mode_o, 0);
    check("R1 rate", rate_o, 0);
    check("R1 volt", volt_o, 4);
    read_reg(6'h03);
    check("R1 timeout", reg_rdata_o, 8);

    // table walk: write, then read back
    foreach (VEC[i]) begin
      reg_addr_i = VEC[i][37:32]; reg_wdata_i = VEC[i][31:16]; reg_we_i = 1;
      tick();
      read_reg(VEC[i][37:32]);
      check("R10/R11/R12 readback", reg_rdata_o, VEC[i][15:0]);
    end
    check("R10 mode_o", mode_o, 3);
    check("R10 rate_o", rate_o, 5);
    check("R10 volt_o", volt_o, 1);

    // R3 running: one core pulse per cycle
    core_edges = 0; tick(4);
    check("R3 running pulses", core_edges, 4);

    // R7 timer expiry with T=6
    wait_start_i = 1; tick(); wait_start_i = 0;
    check("R7 busy after start", timer_busy_o, 1);
    tick(6);
    check("R7 not yet expired", timer_expired_o, 0);
    tick();
    check("R7 expired", timer_expired_o, 1);
    check("R7 busy cleared", timer_busy_o, 0);

    // R8 data halts the wait
    wait_start_i = 1; tick(); wait_start_i = 0;
    check("R8 restart clears expiry", timer_expired_o, 0);
    tick(2);
    chan_valid_i = 1; tick(); chan_valid_i = 0;
    check("R8 busy stopped", timer_busy_o, 0);
    tick(6);
    check("R8 no expiry", timer_expired_o, 0);

    // R2/R3/R4/R9 full sleep and wake
    sleep_req_i = 1; tick(); sleep_req_i = 0;
    check("R2 pm_sleep raised", pm_sleep_o, 1);
    check("R2 not gated yet", gated_o, 0);
    tick();
    check("R2 gated", gated_o, 1);
    core_edges = 0;
    tick(4);
    check("R3 no pulses gated", core_edges, 0);
    chan_valid_i = 1; tick(); chan_valid_i = 0;
    check("R4 gated cleared", gated_o, 0);
    check("R4 pm_sleep cleared", pm_sleep_o, 0);
    check("R4 wake pulse", pm_wake_o, 1);
    check("R9 gated cycles", gated_cnt_o, 5);
    core_edges = 0;
    tick();
    check("R4 wake single", pm_wake_o, 0);
    check("R4 clock resumes", core_edges, 1);
    check("R9 count holds", gated_cnt_o, 5);

    // R12 save store survived the sleep
    read_reg(6'h20);
    check("R12 save kept", reg_rdata_o, 16'hBEEF);

    // R5 request with data in the same cycle
    sleep_req_i = 1; chan_valid_i = 1; tick(); sleep_req_i = 0; chan_valid_i = 0;
    check("R5 no pm_sleep", pm_sleep_o, 0);
    tick();
    check("R5 never gated", gated_o, 0);

    // R6 data in the notify cycle
    sleep_req_i = 1; tick(); sleep_req_i = 0;
    check("R6 notify", pm_sleep_o, 1);
    chan_valid_i = 1; tick(); chan_valid_i = 0;
    check("R6 pm_sleep dropped", pm_sleep_o, 0);
    check("R6 not gated", gated_o, 0);
    tick();
    check("R6 stays running", gated_o, 0);
    check("R9 count unchanged", gated_cnt_o, 5);

    // R1 reset while gated
    sleep_req_i = 1; tick(); sleep_req_i = 0; tick(2);
    check("R1 pre-reset gated", gated_o, 1);
    rst_i = 1; tick(); rst_i = 0;
    check("R1 reset ungates", gated_o, 0);
    check("R1 reset count", gated_cnt_o, 0);
    check("R1 reset volt", volt_o, 4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule